// File: doc/BRIEF.md
# Second-Order Noise-Shaping Word Truncator

This block narrows a 20-bit oscillator control word to a 4-bit code for a coarse digital-to-analog converter. Dropping the 16 low-order bits outright would leave a large, signal-correlated error at low frequency. Instead, the dropped bits are kept as a quantization error and fed back, weighted by +2 from the previous cycle and -1 from the cycle before that. The error then reaches the output filtered by (1 - z^-1)^2, which pushes it toward high frequency where the oscillator's own low-pass response suppresses it.

A new input word is accepted on every enabled clock cycle, and the 4-bit code is registered. The internal sum carries two guard bits so the feedback term cannot wrap. Whenever that sum lies outside the 4-bit range, the code is clipped to 0 or 15. An active-low reset clears the code and both error registers. When the enable is low, the whole state is frozen.

Top module: `dsm2_truncator`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, code_out is 0 and both stored errors are 0.
- R2: code_out is registered: a word applied before a rising edge with en high affects code_out only after that edge.
- R3: The internal sum, ctrl_in + 2*e1 - e2 with e1 and e2 unsigned 16-bit, is held in 22 signed bits. Its upper part (sum shifted right by 16, signed) always lies in [-1, 17], so it never overflows.
- R4: On each enabled edge, code_out takes floor(sum / 2^16) when that value is in [0, 15].
- R5: When floor(sum / 2^16) is above 15, code_out becomes 15. When it is below 0, code_out becomes 0.
- R6: On each enabled edge, the new e1 is the low 16 bits of the sum (sum mod 2^16), and the new e2 is the old e1.
- R7: While en is low, code_out, e1 and e2 keep their values, whatever ctrl_in is.
- R8: For a constant input whose codes never clip, the sum of N successive codes differs from N*ctrl_in/2^16 by no more than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Advance the modulator on this edge |
| ctrl_in | input | 20 | Fine control word, unsigned |
| code_out | output | 4 | Shaped coarse code, unsigned |

## Verification
On every cycle, the assertions check the following: the guard-bit range of the sum, clipping at both ends, the shift of e1 into e2, the freeze while disabled, and the cleared state after reset. The assertions cannot show that the codes follow the true second-order recurrence, or that the long-run average of the codes tracks the input. The bench shows both by running a behavioural model against the design on every cycle and by averaging 4096 codes for several constant inputs.

// File: rtl/dsm2_truncator.sv
module dsm2_truncator #(
  parameter int IN_W  = 20,
  parameter int OUT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [IN_W-1:0]  ctrl_in,
  output logic [OUT_W-1:0] code_out
);
  localparam int FRAC_W = IN_W - OUT_W;
  localparam int SUM_W  = IN_W + 2;
  localparam int HI_W   = SUM_W - FRAC_W;
  localparam logic signed [HI_W-1:0] HI_MAX = HI_W'((2 ** OUT_W) - 1);
  localparam logic signed [HI_W-1:0] HI_TOP = HI_W'((2 ** OUT_W) + 1);
  localparam logic signed [HI_W-1:0] HI_BOT = '1;

  logic [FRAC_W-1:0] err1, err2;
  logic signed [SUM_W-1:0] sum;
  logic signed [HI_W-1:0]  hi;
  logic [OUT_W-1:0]        sat;

  assign sum = $signed({2'b00, ctrl_in})
             + $signed({{(SUM_W-FRAC_W-1){1'b0}}, err1, 1'b0})
             - $signed({{(SUM_W-FRAC_W){1'b0}}, err2});
  assign hi  = sum[SUM_W-1:FRAC_W];
  assign sat = (hi < 0)      ? '0 :
               (hi > HI_MAX) ? '1 : hi[OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err1     <= '0;
      err2     <= '0;
      code_out <= '0;
    end else if (en) begin
      err1     <= sum[FRAC_W-1:0];
      err2     <= err1;
      code_out <= sat;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hi >= HI_BOT) && (hi <= HI_TOP));

  p_sat_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hi > HI_MAX) |=> (code_out == '1));

  p_sat_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hi < 0) |=> (code_out == '0));

  p_err_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (err2 == $past(err1)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(code_out) && $stable(err1) && $stable(err2)));

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (code_out == '0 && err1 == '0 && err2 == '0));
endmodule

// File: tb/tb_dsm2_truncator.sv
module tb_dsm2_truncator;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [19:0] ctrl_in = '0;
  logic [3:0]  code_out;

  int total = 0;
  int bad = 0;
  int m1 = 0, m2 = 0, my = 0;
  bit done = 1'b0;

  dsm2_truncator dut (.clk(clk), .rst_n(rst_n), .en(en), .ctrl_in(ctrl_in), .code_out(code_out));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, update model at posedge, compare at next negedge
  task automatic step(input logic [19:0] x, input bit e, input bit rn);
    int v, q;
    string tag;
    ctrl_in = x; en = e; rst_n = rn;
    #1;
    check("R2", int'(code_out), my); // not yet changed before the edge
    @(posedge clk);
    tag = "R7";
    if (!rn) begin
      m1 = 0; m2 = 0; my = 0; tag = "R1";
    end else if (e) begin
      v  = int'(x) + 2*m1 - m2;
      q  = v >>> 16;
      m2 = m1;
      m1 = v & 32'hFFFF;
      if (q > 15) begin my = 15; tag = "R5"; end
      else if (q < 0) begin my = 0; tag = "R5"; end
      else begin my = q; tag = "R4"; end
    end
    @(negedge clk);
    check(tag, int'(code_out), my);
  endtask

  task automatic avg_run(input logic [19:0] x);
    longint acc = 0;
    longint diff;
    for (int i = 0; i < 4096; i++) begin
      step(x, 1'b1, 1'b1);
      acc += longint'(code_out);
    end
    diff = acc * 65536 - 64'd4096 * longint'(x);
    if (diff < 0) diff = -diff;
    check("R8", (diff <= 2*65536) ? 1 : 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) step(20'h5A5A5, 1'b1, 1'b0);
    check("R1", int'(code_out), 0);
    // first enabled word after reset sees zero stored error (R1, R6)
    step(20'h3_8000, 1'b1, 1'b1);
    check("R1", int'(code_out), 3);
    // error propagation: 0x8000 remainder doubled next cycle (R6)
    step(20'h3_0000, 1'b1, 1'b1);
    check("R6", int'(code_out), 4);
    // assorted patterns (R4)
    for (int i = 0; i < 200; i++) step(20'((i * 37'd52919 + 20'h1234) % 20'hFFFFF), 1'b1, 1'b1);
    // hold while disabled (R7), then resume from held state
    for (int i = 0; i < 8; i++) step(20'hFFFFF - 20'(i), 1'b0, 1'b1);
    for (int i = 0; i < 10; i++) step(20'h6_1357, 1'b1, 1'b1);
    // saturation at both ends (R5)
    for (int i = 0; i < 40; i++) step(20'hFFFFF, 1'b1, 1'b1);
    for (int i = 0; i < 40; i++) step(20'h00001, 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step(20'hF_C000, 1'b1, 1'b1);
    // reset in mid run (R1)
    step(20'h9_9999, 1'b1, 1'b0);
    check("R1", int'(code_out), 0);
    step(20'h2_4000, 1'b1, 1'b1);
    check("R1", int'(code_out), 2);
    // long-run average for constant unclipped inputs (R8)
    avg_run(20'h7_3A5C);
    avg_run(20'h1_8001);
    avg_run(20'hC_FFFF);
    avg_run(20'h4_0000);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule